// File: doc/BRIEF.md
# Framer Error Performance Counters

This block accumulates receive-side error statistics for a DS3/E3 framer. It keeps two 16-bit live counters. The first counts framing errors, and the second counts DS3 P-bit parity errors. An upstream framer supplies one pulse or count per cycle for each event kind. A mode bit selects DS3 or E3, and a 2-bit select chooses which framing events feed the first counter.

Software never reads the live counters. An update strobe copies both live counts into snapshot registers and clears the live counters in the same cycle. The snapshots are read a byte at a time through a combinational read port.

A control input decides what happens while the framer is out of frame. Bit-level and parity errors are either counted during that time or suspended. Loss-of-sync occurrences are always counted.

Top module: `fec_perf_counters`

## Requirements
- R1: After reset, every snapshot byte reads 00h and both live counters are zero.
- R2: A read returns the snapshot latched at the most recent update. Events after that update do not change what is read until the next update.
- R3: On `update_i`, each live count moves into its snapshot and the live counter restarts. An event present in the update cycle counts toward the new interval, so the next update reports it.
- R4: With `cnt_sel_i` = 00, the frame counter adds one per `sync_loss_i` pulse in both modes. This happens regardless of `oof_i` and `cont_oof_i`.
- R5: In DS3 mode (`mode_e3_i` = 0), `cnt_sel_i` picks the frame counter's source. 01 adds `fbit_err_i` + `mbit_err_i`, 10 adds only `fbit_err_i`, and 11 adds only `mbit_err_i`.
- R6: In E3 mode (`mode_e3_i` = 1), `cnt_sel_i` = 01 adds the value of `fas_bit_errs_i`, and 10 adds one per `fas_word_err_i` pulse.
- R7: In E3 mode with `cnt_sel_i` = 11, the frame counter holds its value.
- R8: While `oof_i` = 1 and `cont_oof_i` = 0, nothing is added to the P-bit counter, and nothing is added to the frame counter for selects 01, 10 or 11. With `cont_oof_i` = 1, counting goes on during out-of-frame.
- R9: When `pbit_valid_i` = 1, a parity error is counted if `pbit_a_i` ≠ `pbit_b_i`, or if the two agree but differ from `parity_calc_i`. Nothing is counted when `pbit_valid_i` = 0.
- R10: The P-bit counter never increments in E3 mode.
- R11: Live counters saturate at FFFFh and do not wrap.
- R12: Read map: 24h is the frame snapshot bits 7:0, 25h is its bits 15:8, 26h is the P-bit snapshot bits 7:0, and 27h is its bits 15:8. Any other address reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_e3_i | input | 1 | 0 = DS3, 1 = E3 |
| cnt_sel_i | input | 2 | Frame counter source select |
| cont_oof_i | input | 1 | 1 = keep counting bit/parity errors while out of frame |
| oof_i | input | 1 | Framer out-of-frame status |
| sync_loss_i | input | 1 | Pulse on each loss of receive sync |
| fbit_err_i | input | 1 | DS3 F-bit error pulse |
| mbit_err_i | input | 1 | DS3 M-bit error pulse |
| fas_bit_errs_i | input | FAS_W | E3 count of errored bits in the alignment word this cycle |
| fas_word_err_i | input | 1 | E3 errored alignment word pulse |
| pbit_valid_i | input | 1 | P bits and computed parity valid this cycle |
| pbit_a_i | input | 1 | First received P bit |
| pbit_b_i | input | 1 | Second received P bit |
| parity_calc_i | input | 1 | Parity computed over the information bits |
| update_i | input | 1 | Snapshot-and-clear strobe |
| rd_addr_i | input | 8 | Read byte address |
| rd_data_o | output | 8 | Read byte data |

## Verification
The live counters are hidden from the ports. A wrong increment, a missed gate or a wrong source selection therefore shows up only at the next `update_i`, as a wrong snapshot value. Every update is followed one cycle later by reads at all four addresses. A snapshot that changes between updates is visible in the cycle after the faulty edge. Saturation is proven by driving more than 65,535 events in one interval and checking the snapshot. An error at the update boundary (event lost, or counted twice) shows as an off-by-one split across two consecutive updates.

// File: rtl/fec_pkg.sv
package fec_pkg;
  typedef enum logic [1:0] {
    SEL_SYNC = 2'b00,
    SEL_BOTH = 2'b01,
    SEL_A    = 2'b10,
    SEL_B    = 2'b11
  } cnt_sel_e;

  localparam logic [7:0] ADDR_FE_LO = 8'h24;
  localparam logic [7:0] ADDR_FE_HI = 8'h25;
  localparam logic [7:0] ADDR_PE_LO = 8'h26;
  localparam logic [7:0] ADDR_PE_HI = 8'h27;
endpackage

// File: rtl/fec_event_sel.sv
module fec_event_sel
  import fec_pkg::*;
#(
  parameter int FAS_W = 4,
  parameter int INC_W = FAS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_e3_i,
  input  logic [1:0]       cnt_sel_i,
  input  logic             cont_oof_i,
  input  logic             oof_i,
  input  logic             sync_loss_i,
  input  logic             fbit_err_i,
  input  logic             mbit_err_i,
  input  logic [FAS_W-1:0] fas_bit_errs_i,
  input  logic             fas_word_err_i,
  output logic [INC_W-1:0] inc_o
);
  logic     gate;
  cnt_sel_e sel;

  assign gate = oof_i && !cont_oof_i;
  assign sel  = cnt_sel_e'(cnt_sel_i);

  always_comb begin
    inc_o = '0;
    unique case (sel)
      SEL_SYNC: inc_o = INC_W'(sync_loss_i);
      SEL_BOTH: if (!gate) inc_o = mode_e3_i ? INC_W'(fas_bit_errs_i)
                                             : INC_W'(fbit_err_i) + INC_W'(mbit_err_i);
      SEL_A:    if (!gate) inc_o = mode_e3_i ? INC_W'(fas_word_err_i) : INC_W'(fbit_err_i);
      SEL_B:    if (!gate && !mode_e3_i) inc_o = INC_W'(mbit_err_i);
      default:  inc_o = '0;
    endcase
  end

  assert_e3_illegal_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_e3_i && cnt_sel_i == 2'b11) |-> (inc_o == '0));

  assert_oof_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oof_i && !cont_oof_i && cnt_sel_i != 2'b00) |-> (inc_o == '0));

  assert_sync_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_sel_i == 2'b00 && !sync_loss_i) |-> (inc_o == '0));
endmodule

// File: rtl/fec_pbit_check.sv
module fec_pbit_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_e3_i,
  input  logic cont_oof_i,
  input  logic oof_i,
  input  logic pbit_valid_i,
  input  logic pbit_a_i,
  input  logic pbit_b_i,
  input  logic parity_calc_i,
  output logic perr_o
);
  logic mismatch;

  // pair disagreement, or agreed pair against computed parity
  assign mismatch = (pbit_a_i ^ pbit_b_i) | (pbit_a_i ^ parity_calc_i);
  assign perr_o   = pbit_valid_i && !mode_e3_i && !(oof_i && !cont_oof_i) && mismatch;

  assert_no_e3_perr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_e3_i |-> !perr_o);

  assert_clean_pbits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pbit_a_i == pbit_b_i && pbit_a_i == parity_calc_i) |-> !perr_o);

  assert_pbit_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oof_i && !cont_oof_i) |-> !perr_o);
endmodule

// File: rtl/fec_sat_cnt.sv
module fec_sat_cnt #(
  parameter int CNT_W = 16,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] snap_o
);
  localparam logic [CNT_W-1:0] MAX_V = '1;

  logic [CNT_W-1:0] cnt_q, snap_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else if (clr_i) begin
      snap_q <= cnt_q;
      cnt_q  <= CNT_W'(inc_i);
    end else begin
      cnt_q  <= sum[CNT_W] ? MAX_V : sum[CNT_W-1:0];
    end
  end

  assign snap_o = snap_q;

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_V && !clr_i) |=> (cnt_q == MAX_V));

  assert_snap_copy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (snap_q == $past(cnt_q) && cnt_q == CNT_W'($past(inc_i))));

  assert_snap_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> $stable(snap_q));
endmodule

// File: rtl/fec_perf_counters.sv
module fec_perf_counters
  import fec_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int FAS_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_e3_i,
  input  logic [1:0]       cnt_sel_i,
  input  logic             cont_oof_i,
  input  logic             oof_i,
  input  logic             sync_loss_i,
  input  logic             fbit_err_i,
  input  logic             mbit_err_i,
  input  logic [FAS_W-1:0] fas_bit_errs_i,
  input  logic             fas_word_err_i,
  input  logic             pbit_valid_i,
  input  logic             pbit_a_i,
  input  logic             pbit_b_i,
  input  logic             parity_calc_i,
  input  logic             update_i,
  input  logic [7:0]       rd_addr_i,
  output logic [7:0]       rd_data_o
);
  localparam int INC_W = (FAS_W < 2) ? 2 : FAS_W;

  logic [INC_W-1:0] fe_inc;
  logic             perr;
  logic [CNT_W-1:0] fe_snap, pe_snap;
  logic [15:0]      fe_rd, pe_rd;

  fec_event_sel #(.FAS_W(FAS_W), .INC_W(INC_W)) u_sel (
    .clk_i, .rst_ni, .mode_e3_i, .cnt_sel_i, .cont_oof_i, .oof_i,
    .sync_loss_i, .fbit_err_i, .mbit_err_i, .fas_bit_errs_i, .fas_word_err_i,
    .inc_o(fe_inc)
  );

  fec_pbit_check u_pchk (
    .clk_i, .rst_ni, .mode_e3_i, .cont_oof_i, .oof_i,
    .pbit_valid_i, .pbit_a_i, .pbit_b_i, .parity_calc_i,
    .perr_o(perr)
  );

  fec_sat_cnt #(.CNT_W(CNT_W), .INC_W(INC_W)) u_fe_cnt (
    .clk_i, .rst_ni, .inc_i(fe_inc), .clr_i(update_i), .snap_o(fe_snap)
  );

  fec_sat_cnt #(.CNT_W(CNT_W), .INC_W(1)) u_pe_cnt (
    .clk_i, .rst_ni, .inc_i(perr), .clr_i(update_i), .snap_o(pe_snap)
  );

  // read window is 16 bits wide whatever CNT_W is
  generate
    if (CNT_W >= 16) begin : g_rd_trunc
      assign fe_rd = fe_snap[15:0];
      assign pe_rd = pe_snap[15:0];
    end else begin : g_rd_ext
      assign fe_rd = 16'(fe_snap);
      assign pe_rd = 16'(pe_snap);
    end
  endgenerate

  always_comb begin
    unique case (rd_addr_i)
      ADDR_FE_LO: rd_data_o = fe_rd[7:0];
      ADDR_FE_HI: rd_data_o = fe_rd[15:8];
      ADDR_PE_LO: rd_data_o = pe_rd[7:0];
      ADDR_PE_HI: rd_data_o = pe_rd[15:8];
      default:    rd_data_o = 8'h00;
    endcase
  end

  assert_unmapped_zero_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i[7:2] != 6'b001001) |-> (rd_data_o == 8'h00));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (fe_snap == '0 && pe_snap == '0));
endmodule

// File: tb/fec_perf_counters_bench.sv
`timescale 1ns/1ps
module fec_perf_counters_bench;
  localparam int FAS_W = 4;
  localparam int MAXV  = 65535;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni = 1'b0;
  logic             mode_e3 = 0, cont_oof = 0, oof = 0, sync_loss = 0, fbit = 0, mbit = 0;
  logic [1:0]       sel = 0;
  logic [FAS_W-1:0] fas_bits = 0;
  logic             fas_word = 0, pvalid = 0, pa = 0, pb = 0, pcalc = 0, update = 0;
  logic [7:0]       rd_addr = 0;
  logic [7:0]       rd_data;

  int checks = 0, fails = 0;
  int fe_live = 0, fe_snap = 0, pe_live = 0, pe_snap = 0;

  fec_perf_counters u_fec_perf_counters (
    .clk_i(clk), .rst_ni(rst_ni), .mode_e3_i(mode_e3), .cnt_sel_i(sel),
    .cont_oof_i(cont_oof), .oof_i(oof), .sync_loss_i(sync_loss),
    .fbit_err_i(fbit), .mbit_err_i(mbit), .fas_bit_errs_i(fas_bits),
    .fas_word_err_i(fas_word), .pbit_valid_i(pvalid), .pbit_a_i(pa),
    .pbit_b_i(pb), .parity_calc_i(pcalc), .update_i(update),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic rd16(input logic [7:0] lo, output logic [31:0] v);
    logic [7:0] l, h;
    rd_addr = lo;        #0.3; l = rd_data;
    rd_addr = lo + 8'd1; #0.3; h = rd_data;
    v = {16'h0, h, l};
  endtask

  function automatic int fe_inc_f();
    if (sel == 2'b00) return int'(sync_loss);
    if (oof && !cont_oof) return 0;
    if (!mode_e3) begin
      case (sel)
        2'b01:   return int'(fbit) + int'(mbit);
        2'b10:   return int'(fbit);
        default: return int'(mbit);
      endcase
    end
    case (sel)
      2'b01:   return int'(fas_bits);
      2'b10:   return int'(fas_word);
      default: return 0;
    endcase
  endfunction

  function automatic int pe_inc_f();
    if (mode_e3 || !pvalid || (oof && !cont_oof)) return 0;
    return ((pa != pb) || (pa != pcalc)) ? 1 : 0;
  endfunction

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  // one clock: model steps on the edge, then snapshots compared through the read port
  task automatic cyc();
    logic [31:0] v;
    int fi, pi;
    @(posedge clk);
    fi = fe_inc_f(); pi = pe_inc_f();
    if (update) begin
      fe_snap = fe_live; pe_snap = pe_live;
      fe_live = fi;      pe_live = pi;
    end else begin
      fe_live = sat(fe_live + fi); pe_live = sat(pe_live + pi);
    end
    #0.2;
    rd16(8'h24, v); chk("R2 frame snapshot vs model", v, fe_snap);
    rd16(8'h26, v); chk("R2 P-bit snapshot vs model", v, pe_snap);
  endtask

  task automatic quiet();
    sync_loss = 0; fbit = 0; mbit = 0; fas_bits = 0; fas_word = 0;
    pvalid = 0; pa = 0; pb = 0; pcalc = 0; update = 0; oof = 0;
  endtask

  task automatic upd_check(input string tag, input int fe_exp, input int pe_exp);
    logic [31:0] v;
    update = 1; cyc(); quiet();
    rd16(8'h24, v); chk({tag, " frame"}, v, fe_exp);
    rd16(8'h26, v); chk({tag, " P-bit"}, v, pe_exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #0.5;
    rd16(8'h24, v); chk("R1 reset frame snapshot", v, 0);
    rd16(8'h26, v); chk("R1 reset P snapshot", v, 0);
    @(negedge clk); rst_ni = 1;
    cyc();
    upd_check("R1 live counters zero after reset", 0, 0);

    // R4: sync loss counted in DS3 regardless of OOF gating
    mode_e3 = 0; sel = 2'b00; cont_oof = 0;
    sync_loss = 1; cyc();
    sync_loss = 1; oof = 1; cyc();
    quiet(); cyc();
    sync_loss = 1; cyc(); quiet();
    upd_check("R4 sync loss DS3", 3, 0);
    // R2: new events do not disturb the snapshot
    sync_loss = 1; cyc(); cyc(); quiet();
    rd16(8'h24, v); chk("R2 snapshot held between updates", v, 3);
    // R3: event in update cycle belongs to new interval
    sync_loss = 1; update = 1; cyc(); quiet();
    rd16(8'h24, v); chk("R3 snapshot excludes update-cycle event", v, 2);
    upd_check("R3 update-cycle event in next interval", 1, 0);
    mode_e3 = 1; sync_loss = 1; cyc(); cyc(); quiet();
    upd_check("R4 sync loss E3", 2, 0);

    // R5: DS3 selections
    mode_e3 = 0; sel = 2'b01;
    fbit = 1; mbit = 1; cyc(); mbit = 0; cyc(); quiet();
    upd_check("R5 DS3 F+M", 3, 0);
    sel = 2'b10; fbit = 1; mbit = 1; cyc(); fbit = 0; cyc(); quiet();
    upd_check("R5 DS3 F only", 1, 0);
    sel = 2'b11; fbit = 1; mbit = 1; cyc(); mbit = 0; cyc(); quiet();
    upd_check("R5 DS3 M only", 1, 0);

    // R6: E3 selections
    mode_e3 = 1; sel = 2'b01;
    fas_bits = 5; cyc(); fas_bits = 3; fbit = 1; cyc(); quiet();
    upd_check("R6 E3 FAS bit errors", 8, 0);
    sel = 2'b10; fas_word = 1; fas_bits = 7; cyc(); cyc(); quiet();
    upd_check("R6 E3 FAS word errors", 2, 0);
    // R7: illegal select holds
    sel = 2'b11; fas_word = 1; fas_bits = 9; fbit = 1; mbit = 1; sync_loss = 1; cyc(); cyc(); quiet();
    upd_check("R7 E3 illegal select holds", 0, 0);

    // R8: OOF gating
    mode_e3 = 0; sel = 2'b01; cont_oof = 0;
    oof = 1; fbit = 1; pvalid = 1; pa = 1; cyc(); cyc(); quiet();
    upd_check("R8 suspended during OOF", 0, 0);
    cont_oof = 1; oof = 1; fbit = 1; pvalid = 1; pa = 1; cyc(); cyc(); quiet();
    upd_check("R8 continue during OOF", 2, 2);

    // R9: parity error definition
    sel = 2'b00;
    pvalid = 1; pa = 1; pb = 0; pcalc = 0; cyc();
    pa = 1; pb = 1; pcalc = 0; cyc();
    pa = 1; pb = 1; pcalc = 1; cyc();
    pa = 0; pb = 0; pcalc = 0; cyc();
    pvalid = 0; pa = 1; pb = 0; cyc(); quiet();
    upd_check("R9 P-bit error rule", 0, 2);
    // R10: no P counting in E3
    mode_e3 = 1; cont_oof = 1; pvalid = 1; pa = 1; pb = 0; cyc(); cyc(); quiet();
    upd_check("R10 E3 P counter frozen", 0, 0);

    // R11: saturation
    mode_e3 = 1; sel = 2'b01;
    fas_bits = 4'hF;
    for (int i = 0; i < 4400; i++) cyc();
    quiet();
    upd_check("R11 saturate", MAXV, 0);
    // R12: byte map
    rd_addr = 8'h24; #0.2; chk("R12 24h low byte", rd_data, 8'hFF);
    rd_addr = 8'h25; #0.2; chk("R12 25h high byte", rd_data, 8'hFF);
    rd_addr = 8'h27; #0.2; chk("R12 27h P high byte", rd_data, 8'h00);
    rd_addr = 8'h00; #0.2; chk("R12 unmapped 00h", rd_data, 8'h00);
    rd_addr = 8'h28; #0.2; chk("R12 unmapped 28h", rd_data, 8'h00);
    rd_addr = 8'h23; #0.2; chk("R12 unmapped 23h", rd_data, 8'h00);

    // mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      mode_e3   = $urandom_range(0, 1);
      sel       = 2'($urandom_range(0, 3));
      cont_oof  = $urandom_range(0, 1);
      oof       = ($urandom_range(0, 3) == 0);
      sync_loss = $urandom_range(0, 1);
      fbit      = $urandom_range(0, 1);
      mbit      = $urandom_range(0, 1);
      fas_bits  = FAS_W'($urandom_range(0, 15));
      fas_word  = $urandom_range(0, 1);
      pvalid    = $urandom_range(0, 1);
      pa        = $urandom_range(0, 1);
      pb        = $urandom_range(0, 1);
      pcalc     = $urandom_range(0, 1);
      update    = ($urandom_range(0, 15) == 0);
      cyc();
    end
    quiet();
    update = 1; cyc(); quiet(); cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule